// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates among every interrupt and reset request of a small 16-bit processor and tells the core which vector-table word to fetch next. Thirty-two fixed priority slots each map to one word of the table. The top slot gathers all reset causes. The slot below it gathers the non-maskable sources, and each of those can still be switched off by its own enable. The remaining thirty slots are ordinary maskable requests. A maskable request counts only when its own enable and the global interrupt enable are both set.

The core watches `irq_req`. When the core is ready to enter a handler it raises `irq_take` for one cycle. In the following cycle the controller presents the registered vector address and slot number, pulses `ack` for one cycle, and, when the slot has only one source, pulses that slot's bit of `flag_clr` so the peripheral can drop its flag. The block has two more duties. After reset it samples the reset-vector word and holds `lpm_force` high when that word is blank (all ones). It also flags any instruction fetch that falls outside the populated memory regions, so that reset logic can act on it.

Top module: `irq_vector_ctl`

## Requirements
- R1: `vec_addr` equals 16'hFFC0 + 2 × `vec_slot`. Slot 31 maps to 16'hFFFE and slot 0 maps to 16'hFFC0.
- R2: When several slots are eligible, the slot with the highest number is selected.
- R3: Any bit of `rst_req` makes slot 31 eligible, whatever the values of `gie` and the other inputs.
- R4: Slot 30 is eligible when at least one bit of `nmi_flag & nmi_en` is set. `gie` has no effect on it.
- R5: A maskable slot i (0..29) is eligible only when `irq_flag[i]`, `irq_en[i]` and `gie` are all 1.
- R6: `irq_req` is high in the same cycle that any slot is eligible, and low otherwise.
- R7: The cycle after `irq_take` is sampled high with `irq_req` high, `vec_slot` and `vec_addr` show the winner and `ack` is high for exactly that cycle. Otherwise `ack` is low and the vector outputs hold their values.
- R8: `flag_clr[i]` pulses together with `ack` only when the winner is a maskable slot i that has a single source. Shared slots 18, 19, 22, 23, 24 and 28, as well as slots 30 and 31, never pulse it. At most one bit is set at a time.
- R9: On the first clock after reset, `lpm_force` becomes 1 if `rvec_word` is 16'hFFFF and 0 otherwise. It then holds that value until the next reset.
- R10: One cycle after a valid fetch, `fetch_fault` is 1 when `fetch_addr` lies outside all of these regions: 0200h–03FFh, 0C00h–0FFFh, 1000h–10FFh and E000h–FFFFh. This includes the register space 0000h–01FFh. Otherwise `fetch_fault` is 0.
- R11: During and right after reset, `vec_slot` is 31, `vec_addr` is 16'hFFFE, and `ack`, `flag_clr` and `fetch_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global enable for maskable slots |
| rst_req | input | 5 | Reset-cause requests (slot 31) |
| nmi_flag | input | 3 | Non-maskable source flags (slot 30) |
| nmi_en | input | 3 | Per-source enables for slot 30 |
| irq_flag | input | 30 | Maskable flags, bit i = slot i |
| irq_en | input | 30 | Maskable enables, bit i = slot i |
| irq_take | input | 1 | Core accepts the current request |
| rvec_word | input | 16 | Contents of the reset vector word |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| irq_req | output | 1 | Some slot is eligible |
| vec_addr | output | 16 | Registered vector-table address |
| vec_slot | output | 5 | Registered winning slot |
| ack | output | 1 | One-cycle acknowledge |
| flag_clr | output | 30 | Auto-clear pulse for single-source slots |
| lpm_force | output | 1 | Blank reset vector: hold the deepest sleep mode |
| fetch_fault | output | 1 | Fetch hit an unpopulated region |

## Verification
The properties assume that `irq_take` is driven only from the clock edge and that the request inputs do not change between the edge at which a take is sampled and the decision it produces. Both hold because every input is driven on the falling edge and sampled on the rising edge. The vector-address property also assumes the default table base. The bench never overrides any parameter, so that base is always in use. The bench changes `rvec_word` only around a reset, and it also moves the word after reset to show that `lpm_force` does not follow it.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int          RST_SRCS     = 5,
  parameter int          NMI_SRCS     = 3,
  parameter logic [15:0] TABLE_BASE   = 16'hFFC0,
  parameter logic [29:0] SHARED_SLOTS = 30'h11CC_0000,
  parameter logic [15:0] RAM_LO       = 16'h0200,
  parameter logic [15:0] RAM_HI       = 16'h03FF,
  parameter logic [15:0] BOOT_LO      = 16'h0C00,
  parameter logic [15:0] BOOT_HI      = 16'h0FFF,
  parameter logic [15:0] INFO_LO      = 16'h1000,
  parameter logic [15:0] INFO_HI      = 16'h10FF,
  parameter logic [15:0] CODE_LO      = 16'hE000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gie,
  input  logic [RST_SRCS-1:0] rst_req,
  input  logic [NMI_SRCS-1:0] nmi_flag,
  input  logic [NMI_SRCS-1:0] nmi_en,
  input  logic [29:0]         irq_flag,
  input  logic [29:0]         irq_en,
  input  logic                irq_take,
  input  logic [15:0]         rvec_word,
  input  logic                fetch_vld,
  input  logic [15:0]         fetch_addr,
  output logic                irq_req,
  output logic [15:0]         vec_addr,
  output logic [4:0]          vec_slot,
  output logic                ack,
  output logic [29:0]         flag_clr,
  output logic                lpm_force,
  output logic                fetch_fault
);
  localparam int SLOTS = 32;
  localparam int MSLOT = SLOTS - 2;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SW-1:0] TOP = SW'(SLOTS - 1);

  logic [SLOTS-1:0] elig;
  logic [SW-1:0]    win;
  logic [MSLOT-1:0] clr_nx;
  logic             boot_q;
  logic             addr_ok;

  assign elig[SLOTS-1]   = |rst_req;
  assign elig[SLOTS-2]   = |(nmi_flag & nmi_en);
  assign elig[MSLOT-1:0] = irq_flag & irq_en & {MSLOT{gie}};
  assign irq_req         = |elig;

  always_comb begin
    win = '0;
    for (int i = 0; i < SLOTS; i++)
      if (elig[i]) win = SW'(i);
  end

  always_comb begin
    for (int i = 0; i < MSLOT; i++)
      clr_nx[i] = (win == SW'(i)) && !SHARED_SLOTS[i];
  end

  assign addr_ok = (fetch_addr >= RAM_LO  && fetch_addr <= RAM_HI)  ||
                   (fetch_addr >= BOOT_LO && fetch_addr <= BOOT_HI) ||
                   (fetch_addr >= INFO_LO && fetch_addr <= INFO_HI) ||
                   (fetch_addr >= CODE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_slot <= TOP;
      vec_addr <= TABLE_BASE + {10'd0, TOP, 1'b0};
      ack      <= 1'b0;
      flag_clr <= '0;
    end else if (irq_take && irq_req) begin
      vec_slot <= win;
      vec_addr <= TABLE_BASE + {10'd0, win, 1'b0};
      ack      <= 1'b1;
      flag_clr <= clr_nx;
    end else begin
      ack      <= 1'b0;
      flag_clr <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      lpm_force <= 1'b0;
    end else if (boot_q) begin
      boot_q    <= 1'b0;
      lpm_force <= (rvec_word == 16'hFFFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_fault <= 1'b0;
    else        fetch_fault <= fetch_vld && !addr_ok;
  end
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk #(
  parameter int RST_SRCS = 5,
  parameter int NMI_SRCS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gie,
  input logic [RST_SRCS-1:0] rst_req,
  input logic [NMI_SRCS-1:0] nmi_flag,
  input logic [NMI_SRCS-1:0] nmi_en,
  input logic                irq_take,
  input logic                irq_req,
  input logic [15:0]         vec_addr,
  input logic [4:0]          vec_slot,
  input logic                ack,
  input logic [29:0]         flag_clr,
  input logic                lpm_force
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_vec_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr == {10'h3FF, vec_slot, 1'b0});
  assert_reset_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && |rst_req) |=> (vec_slot == 5'd31));
  assert_nmi_nogie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !(|rst_req) && |(nmi_flag & nmi_en)) |=> (vec_slot == 5'd30 && ack));
  assert_gie_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !gie && !(|rst_req) && !(|(nmi_flag & nmi_en))) |=> !ack);
  assert_ack_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_req) |=> ack);
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take && irq_req) |=> (!ack && $stable(vec_slot)));
  assert_clr_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> (ack && $onehot0(flag_clr)));
  assert_lpm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> $stable(lpm_force));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk #(.RST_SRCS(RST_SRCS), .NMI_SRCS(NMI_SRCS)) u_chk (.*);

// File: tb/irq_vector_ctl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic [4:0]  rst_req = '0;
  logic [2:0]  nmi_flag = '0, nmi_en = '0;
  logic [29:0] irq_flag = '0, irq_en = '0;
  logic        irq_take = 1'b0;
  logic [15:0] rvec_word = 16'h1234;
  logic        fetch_vld = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        irq_req, ack, lpm_force, fetch_fault;
  logic [15:0] vec_addr;
  logic [4:0]  vec_slot;
  logic [29:0] flag_clr;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_vector_ctl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    gie = 0; rst_req = '0; nmi_flag = '0; nmi_en = '0;
    irq_flag = '0; irq_en = '0; irq_take = 0; fetch_vld = 0;
  endtask

  task automatic do_reset(input logic [15:0] rv);
    @(negedge clk);
    clear_inputs();
    rvec_word = rv;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic take_and_check(input string req, input logic [4:0] slot,
                                input logic [29:0] clr_exp);
    @(negedge clk);
    irq_take = 1;
    @(negedge clk);
    irq_take = 0;
    chk({req, " slot"}, 32'(vec_slot), 32'(slot));
    chk({req, " addr"}, 32'(vec_addr), 32'(16'hFFC0 + 16'(slot) * 16'd2));
    chk({req, " ack"}, 32'(ack), 1);
    chk({req, " clr"}, 32'(flag_clr), 32'(clr_exp));
    @(negedge clk);
    chk("R7 ack pulse ends", 32'(ack), 0);
    chk("R7 vector holds", 32'(vec_slot), 32'(slot));
    chk("R8 clr pulse ends", 32'(flag_clr), 0);
  endtask

  task automatic t_reset_state();
    do_reset(16'h1234);
    chk("R11 slot", 32'(vec_slot), 31);
    chk("R11 addr", 32'(vec_addr), 32'hFFFE);
    chk("R11 ack", 32'(ack), 0);
    chk("R11 clr", 32'(flag_clr), 0);
    chk("R11 fault", 32'(fetch_fault), 0);
    chk("R6 idle req", 32'(irq_req), 0);
    chk("R9 programmed vector", 32'(lpm_force), 0);
  endtask

  task automatic t_single_maskable();
    @(negedge clk); clear_inputs();
    gie = 1; irq_flag[29] = 1; irq_en[29] = 1;
    #1 chk("R6 req", 32'(irq_req), 1);
    take_and_check("R1 R7 slot29", 5'd29, 30'(1) << 29);
  endtask

  task automatic t_enable_gating();
    @(negedge clk); clear_inputs();
    irq_flag[5] = 1; irq_en[5] = 1; gie = 0;
    #1 chk("R5 no gie", 32'(irq_req), 0);
    @(negedge clk); irq_take = 1;
    @(negedge clk); irq_take = 0;
    chk("R5 no ack without gie", 32'(ack), 0);
    chk("R5 vector unchanged", 32'(vec_slot), 29);
    gie = 1; irq_en[5] = 0;
    #1 chk("R5 no own enable", 32'(irq_req), 0);
    irq_en[5] = 1;
    #1 chk("R5 both enables", 32'(irq_req), 1);
  endtask

  task automatic t_priority();
    @(negedge clk); clear_inputs();
    gie = 1;
    irq_flag = (30'(1) << 3) | (30'(1) << 17) | (30'(1) << 26);
    irq_en = '1;
    take_and_check("R2 three pending", 5'd26, 30'(1) << 26);
    irq_flag[26] = 0;
    take_and_check("R2 next lower", 5'd17, 30'(1) << 17);
  endtask

  task automatic t_shared();
    @(negedge clk); clear_inputs();
    gie = 1; irq_flag[28] = 1; irq_en[28] = 1; irq_flag[22] = 1; irq_en[22] = 1;
    take_and_check("R8 shared slot28", 5'd28, '0);
    irq_flag[28] = 0;
    take_and_check("R8 shared slot22", 5'd22, '0);
  endtask

  task automatic t_nmi();
    @(negedge clk); clear_inputs();
    gie = 0; irq_flag = '1; irq_en = '1;
    nmi_flag[1] = 1; nmi_en[1] = 0;
    #1 chk("R4 own enable blocks", 32'(irq_req), 0);
    nmi_en[1] = 1;
    #1 chk("R4 ignores gie", 32'(irq_req), 1);
    take_and_check("R4 slot30", 5'd30, '0);
  endtask

  task automatic t_reset_src();
    @(negedge clk); clear_inputs();
    gie = 1; irq_flag = '1; irq_en = '1; nmi_flag = '1; nmi_en = '1;
    rst_req[2] = 1;
    take_and_check("R3 reset over all", 5'd31, '0);
    gie = 0; nmi_en = '0;
    take_and_check("R3 reset without gie", 5'd31, '0);
  endtask

  task automatic t_lowest();
    @(negedge clk); clear_inputs();
    gie = 1; irq_flag[0] = 1; irq_en[0] = 1;
    take_and_check("R1 slot0", 5'd0, 30'd1);
    chk("R1 bottom address", 32'(vec_addr), 32'hFFC0);
  endtask

  task automatic fetch(input logic [15:0] a, input logic exp, input string req);
    @(negedge clk); fetch_vld = 1; fetch_addr = a;
    @(negedge clk); fetch_vld = 0;
    chk(req, 32'(fetch_fault), 32'(exp));
  endtask

  task automatic t_fetch();
    @(negedge clk); clear_inputs();
    fetch(16'h0000, 1, "R10 register space low");
    fetch(16'h01FF, 1, "R10 register space top");
    fetch(16'h0200, 0, "R10 ram base");
    fetch(16'h0400, 1, "R10 gap above ram");
    fetch(16'h0C00, 0, "R10 boot area");
    fetch(16'h10FF, 0, "R10 info top");
    fetch(16'h1100, 1, "R10 gap above info");
    fetch(16'hDFFF, 1, "R10 below code");
    fetch(16'hE000, 0, "R10 code base");
    @(negedge clk); fetch_addr = 16'h0000;
    @(negedge clk);
    chk("R10 no strobe no fault", 32'(fetch_fault), 0);
  endtask

  task automatic t_lpm();
    do_reset(16'hFFFF);
    chk("R9 blank vector", 32'(lpm_force), 1);
    rvec_word = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R9 holds after word changes", 32'(lpm_force), 1);
    do_reset(16'hFFFE);
    chk("R9 nearly blank vector", 32'(lpm_force), 0);
    rvec_word = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R9 holds low", 32'(lpm_force), 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_single_maskable();
    t_enable_gating();
    t_priority();
    t_shared();
    t_nmi();
    t_reset_src();
    t_lowest();
    t_fetch();
    t_lpm();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule